// File: doc/BRIEF.md
# Tree Pseudo-LRU Way Selector

This block keeps the replacement state for a single set of a four-way set-associative cache. It uses three tree bits. On every cycle it names the way that a fill should overwrite. If any way is invalid, the lowest-numbered invalid way is named and the tree is not used. When all four ways are valid, the tree picks a way that was not referenced recently.

The surrounding cache pulses `ref_en` with `ref_way` when a hit occurs. It pulses `fill_en` when it writes the named victim. Both kinds of event move the tree on the next rising clock edge. The victim output is purely combinational from the tree and `way_valid`.

Tree bit 0 is the root and records which half (ways 0-1 or ways 2-3) was touched more recently: 1 means the low half. Bit 1 records the winner within ways 0-1 (1 means way 0). Bit 2 records the winner within ways 2-3 (1 means way 2).

Top module: `plru_way_select`

## Requirements
- R1: While `rst` is high at a rising edge, all three tree bits become 0. With all ways valid, the victim is then way 0.
- R2: With `way_valid` = 4'b1111, the victim follows the tree bits, read as bit0 bit1 bit2: 00x gives way 0, 01x gives way 1, 1x0 gives way 2 and 1x1 gives way 3.
- R3: If any bit of `way_valid` is 0, the victim is the lowest-numbered way whose valid bit is 0, whatever the tree holds.
- R4: A reference to way 0 sets bit0=1 and bit1=1. A reference to way 1 sets bit0=1 and bit1=0. In both cases bit2 keeps its value.
- R5: A reference to way 2 sets bit0=0 and bit2=1. A reference to way 3 sets bit0=0 and bit2=0. In both cases bit1 keeps its value.
- R6: `fill_en` without `ref_en` updates the tree exactly as a reference to the victim shown in that cycle, including a victim chosen because it is invalid.
- R7: When `ref_en` and `fill_en` are both high, only `ref_way` is applied and the fill is ignored.
- R8: With neither `ref_en` nor `fill_en` high, the tree holds its value.
- R9: Updates take effect at the next rising edge. The victim reacts to `way_valid` within the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference (hit) strobe |
| ref_way | input | 2 | Way referenced when `ref_en` is high |
| fill_en | input | 1 | Fill into the current victim |
| way_valid | input | 4 | Valid bit per way, bit n for way n |
| victim | output | 2 | Way to replace |

## Verification
A wrong tree state is visible only on `victim`, and only while all four ways are valid. A bad root bit shows up in the first such cycle. A bad bit1 or bit2 stays hidden until the root points at that half, which can take an arbitrary number of references. For that reason, the stimulus mixes long all-valid stretches with references that flip the root back and forth, and compares the victim against a recency model every cycle. Fills at invalid ways show up later, once all ways turn valid.

// File: rtl/plru_way_select.sv
module plru_way_select (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_en,
  input  logic [1:0] ref_way,
  input  logic       fill_en,
  input  logic [3:0] way_valid,
  output logic [1:0] victim
);

  logic [2:0] tree;
  logic [1:0] tree_pick;
  logic [1:0] free_pick;
  logic [1:0] touch_way;
  logic       touch;
  logic       all_valid;

  assign all_valid = &way_valid;
  assign tree_pick = tree[0] ? {1'b1, tree[2]} : {1'b0, tree[1]};

  always_comb begin
    casez (way_valid)
      4'b???0: free_pick = 2'd0;
      4'b??01: free_pick = 2'd1;
      4'b?011: free_pick = 2'd2;
      4'b0111: free_pick = 2'd3;
      default: free_pick = 2'd0;
    endcase
  end

  assign victim    = all_valid ? tree_pick : free_pick;
  assign touch     = ref_en | fill_en;
  assign touch_way = ref_en ? ref_way : victim;

  always_ff @(posedge clk) begin
    if (rst) begin
      tree <= 3'b000;
    end else if (touch) begin
      tree[0] <= ~touch_way[1];
      if (touch_way[1]) tree[2] <= ~touch_way[0];
      else              tree[1] <= ~touch_way[0];
    end
  end

endmodule

module plru_way_select_sva (
  input logic       clk,
  input logic       rst,
  input logic       ref_en,
  input logic [1:0] ref_way,
  input logic       fill_en,
  input logic [3:0] way_valid,
  input logic [1:0] victim,
  input logic [2:0] tree
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> tree == 3'b000); // R1
  AST_INVALID_CHOSEN: assert property (@(posedge clk) disable iff (rst) !(&way_valid) |-> !way_valid[victim]); // R3
  AST_LOWEST_INVALID: assert property (@(posedge clk) disable iff (rst) !(&way_valid) |-> ((way_valid & ((4'b0001 << victim) - 4'b0001)) == ((4'b0001 << victim) - 4'b0001))); // R3
  AST_REF_LOW_HALF: assert property (@(posedge clk) disable iff (rst) (ref_en && !ref_way[1]) |=> (tree[0] && tree[1] == !$past(ref_way[0]) && tree[2] == $past(tree[2]))); // R4
  AST_REF_HIGH_HALF: assert property (@(posedge clk) disable iff (rst) (ref_en && ref_way[1]) |=> (!tree[0] && tree[2] == !$past(ref_way[0]) && tree[1] == $past(tree[1]))); // R5
  AST_FILL_TOUCHES_VICTIM: assert property (@(posedge clk) disable iff (rst) (fill_en && !ref_en) |=> tree[0] == !$past(victim[1])); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) (!ref_en && !fill_en) |=> $stable(tree)); // R8

endmodule

bind plru_way_select plru_way_select_sva u_sva (
  .clk(clk), .rst(rst), .ref_en(ref_en), .ref_way(ref_way), .fill_en(fill_en),
  .way_valid(way_valid), .victim(victim), .tree(tree)
);

// File: tb/plru_way_select_test.sv
module plru_way_select_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_en = 1'b0;
  logic [1:0] ref_way = 2'd0;
  logic       fill_en = 1'b0;
  logic [3:0] way_valid = 4'b1111;
  logic [1:0] victim;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // recency model: which half was touched last, and last touched way per half
  int last_half  = 1;
  int last_low   = 1;
  int last_high  = 3;

  plru_way_select uut (
    .clk(clk), .rst(rst), .ref_en(ref_en), .ref_way(ref_way),
    .fill_en(fill_en), .way_valid(way_valid), .victim(victim)
  );

  always #5 clk = ~clk;

  function automatic int model_victim(logic [3:0] v);
    for (int i = 0; i < 4; i++) if (!v[i]) return i;
    if (last_half == 1) return (last_low == 0) ? 1 : 0;
    return (last_high == 2) ? 3 : 2;
  endfunction

  task automatic model_touch(int w);
    last_half = w / 2;
    if (w < 2) last_low = w; else last_high = w;
  endtask

  task automatic check(string tag);
    int exp;
    exp = model_victim(way_valid);
    checks++;
    if (victim !== exp[1:0]) begin
      errors++;
      $display("FAIL %s: victim=%0d expected=%0d valid=%b", tag, victim, exp, way_valid);
    end
  endtask

  task automatic step(bit r, int w, bit f, logic [3:0] v, string tag);
    int vict;
    ref_en = r; ref_way = w[1:0]; fill_en = f; way_valid = v;
    #1 check(tag);
    vict = model_victim(v);
    @(posedge clk);
    if (r) model_touch(w);
    else if (f) model_touch(vict);
    @(negedge clk);
    ref_en = 1'b0; fill_en = 1'b0;
    way_valid = 4'b1111;
    #1 check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, victim way 0 when all valid
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1");

    // R4: low-half references
    step(1, 0, 0, 4'b1111, "R4");
    step(1, 1, 0, 4'b1111, "R4");
    // R5: high-half references; bit1 kept
    step(1, 2, 0, 4'b1111, "R5");
    step(1, 3, 0, 4'b1111, "R5");
    step(1, 0, 0, 4'b1111, "R5");
    // R2: all four tree outcomes
    step(1, 3, 0, 4'b1111, "R2");
    step(1, 1, 0, 4'b1111, "R2");
    step(1, 2, 0, 4'b1111, "R2");
    step(1, 0, 0, 4'b1111, "R2");

    // R3: invalid priority, lowest invalid
    step(0, 0, 0, 4'b1011, "R3");
    step(0, 0, 0, 4'b0110, "R3");
    step(0, 0, 0, 4'b0111, "R3");
    step(0, 0, 0, 4'b0000, "R3");

    // R9: victim reacts combinationally to valid changes
    way_valid = 4'b1101; #1 check("R9");
    way_valid = 4'b1111; #1 check("R9");

    // R6: fills update like a reference to the victim
    step(0, 0, 1, 4'b1111, "R6");
    step(0, 0, 1, 4'b1111, "R6");
    step(0, 0, 1, 4'b1011, "R6");
    step(0, 0, 1, 4'b1110, "R6");

    // R7: reference wins over simultaneous fill
    step(1, 3, 1, 4'b1111, "R7");
    step(1, 0, 1, 4'b1111, "R7");

    // R8: idle cycles hold state
    step(0, 0, 0, 4'b1111, "R8");
    step(0, 2, 0, 4'b1111, "R8");

    // mixed stimulus
    for (int n = 0; n < 400; n++) begin
      int w;
      logic [3:0] v;
      w = $urandom_range(0, 3);
      v = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'b1111;
      step($urandom_range(0, 1) == 1, w, $urandom_range(0, 2) == 0, v, "R2");
    end

    // R1: reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    last_half = 1; last_low = 1; last_high = 3;
    #1 check("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule